// File: doc/BRIEF.md
# IR Pulse Frame Transmitter

This block drives an infrared emitter line with one coded frame per start strobe. A frame is made of an optional leading head symbol, a run of data symbols sent least significant bit first, and an optional trailing tail symbol. Every symbol has two timed phases. Phase 1 is driven first and phase 0 second. A phase width field holding N lasts N+1 time units. One time unit lasts (unit field + 1) clock cycles.

Each symbol kind (head, one, zero, tail) has its own pair of widths and its own swap control, which exchanges the levels of its two phases. The active level can be replaced by a free-running carrier. The whole line can be inverted, which also sets the idle level. Frames are normally followed by an idle gap as long as a tail symbol. Continue mode removes that gap. Free-run mode repeats frames until a stop request is seen.

The configuration and the data word are captured when a start strobe is accepted, and they are held for the whole transfer. The line, the busy flag and the end pulse all come from registers.

Top module: `irtx_frame`

## Requirements
- R1: After reset, `ir_o`, `busy_o` and `done_o` are all 0.
- R2: One clock cycle after the start edge, `busy_o` is 1 and `ir_o` shows the first phase. The frame order is head (if `head_en_i`), then data bits (if `data_en_i`), then tail (if `tail_en_i`). Data bits go out LSB first, and each bit uses the one-symbol or the zero-symbol settings.
- R3: Each symbol drives phase 1 and then phase 0. A phase with width field W lasts (W+1)*(`unit_i`+1) clock cycles. Without swap, phase 1 is active (1) and phase 0 is inactive (0).
- R4: When a symbol's swap bit is set (`head_swap_i`, `one_swap_i`, `zero_swap_i`, `tail_swap_i`), phase 1 is inactive and phase 0 is active for that symbol.
- R5: Outside free-run mode, exactly `nbits_i`+1 data bits are sent (1 to 32).
- R6: With `mod_en_i` set, the active level becomes a carrier. The carrier is high for `car_hi_i`+1 cycles, then low for `car_lo_i`+1 cycles, repeating. The first high cycle coincides with the first frame cycle.
- R7: `ir_o` is inverted when `inv_out_i` is set. When idle, `ir_o` equals the live `inv_out_i`.
- R8: Without `cont_i`, each frame is followed by an inactive gap of (`tail_w1_i`+`tail_w0_i`+2) units, still inside busy. With `cont_i`, there is no gap.
- R9: In free-run mode, each frame carries all 32 bits and `nbits_i` is ignored. Frames repeat back to back. A stop request ends the transfer after the frame (and gap) in progress. A stop sampled on a frame's last cycle ends the transfer at that frame.
- R10: `done_o` is a one-cycle pulse in the first cycle in which `busy_o` is 0 after a transfer.
- R11: A start while busy is ignored, and so are configuration changes during a transfer. A start is also ignored when no part of the frame is enabled and `cont_i` is set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start_i | input | 1 | Start strobe |
| stop_i | input | 1 | Stop request for free-run mode |
| unit_i | input | 16 | Time unit minus one, in clock cycles |
| head_w1_i | input | 8 | Head phase 1 width |
| head_w0_i | input | 8 | Head phase 0 width |
| one_w1_i | input | 8 | One-bit phase 1 width |
| one_w0_i | input | 8 | One-bit phase 0 width |
| zero_w1_i | input | 8 | Zero-bit phase 1 width |
| zero_w0_i | input | 8 | Zero-bit phase 0 width |
| tail_w1_i | input | 8 | Tail phase 1 width (also the first part of the gap) |
| tail_w0_i | input | 8 | Tail phase 0 width (also the second part of the gap) |
| car_hi_i | input | 8 | Carrier high cycles minus one |
| car_lo_i | input | 8 | Carrier low cycles minus one |
| head_en_i | input | 1 | Send head symbol |
| data_en_i | input | 1 | Send data symbols |
| tail_en_i | input | 1 | Send tail symbol |
| head_swap_i | input | 1 | Swap head phase levels |
| one_swap_i | input | 1 | Swap one-bit phase levels |
| zero_swap_i | input | 1 | Swap zero-bit phase levels |
| tail_swap_i | input | 1 | Swap tail phase levels |
| mod_en_i | input | 1 | Replace active level by carrier |
| inv_out_i | input | 1 | Invert line, idle high |
| cont_i | input | 1 | No gap between frames |
| freerun_i | input | 1 | Repeat frames until stopped |
| nbits_i | input | 5 | Data bits per frame minus one |
| data_i | input | 32 | Frame data word |
| ir_o | output | 1 | IR line |
| busy_o | output | 1 | Transfer in progress |
| done_o | output | 1 | End-of-transfer pulse |

## Verification
In free-run mode, the end of a frame and a stop request can land on the same clock edge. The stop must then win over the restart, and the transfer must end at that frame. The bench raises the stop request exactly on the last cycle of the first frame, and again one cycle later. It expects one frame in the first case and two frames in the second. It judges each case by the cycle on which `done_o` pulses and by the full waveform up to that cycle. A start strobe that arrives together with changed settings in the middle of a frame is also checked: the frame must carry on exactly as first configured.

// File: rtl/irtx_pkg.sv
package irtx_pkg;

  typedef enum logic [2:0] {
    SEG_IDLE,
    SEG_HEAD,
    SEG_DATA,
    SEG_TAIL,
    SEG_GAP
  } seg_e;

  // symbol kinds index the packed width arrays
  localparam int K_HEAD = 0;
  localparam int K_ONE  = 1;
  localparam int K_ZERO = 2;
  localparam int K_TAIL = 3;
  localparam int N_KIND = 4;

  typedef struct packed {
    logic head_en;
    logic data_en;
    logic tail_en;
    logic head_swap;
    logic one_swap;
    logic zero_swap;
    logic tail_swap;
    logic mod_en;
    logic inv_out;
    logic cont;
    logic freerun;
  } irtx_flags_t;

endpackage

// File: rtl/irtx_unit_timer.sv
module irtx_unit_timer #(
  parameter int UNIT_W = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              restart,
  input  logic [UNIT_W-1:0] unit,
  output logic              tick
);

  logic [UNIT_W-1:0] cnt;

  assign tick = (cnt == unit);

  always_ff @(posedge clk) begin
    if (rst || restart) cnt <= '0;
    else if (tick)      cnt <= '0;
    else                cnt <= cnt + 1'b1;
  end

endmodule

// File: rtl/irtx_carrier.sv
module irtx_carrier #(
  parameter int CAR_W = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             restart,
  input  logic [CAR_W-1:0] hi_w,
  input  logic [CAR_W-1:0] lo_w,
  output logic             car
);

  logic [CAR_W-1:0] cnt;
  logic             hi;

  assign car = hi;

  always_ff @(posedge clk) begin
    if (rst || restart) begin
      cnt <= '0;
      hi  <= 1'b1;
    end else if (hi && cnt == hi_w) begin
      cnt <= '0;
      hi  <= 1'b0;
    end else if (!hi && cnt == lo_w) begin
      cnt <= '0;
      hi  <= 1'b1;
    end else begin
      cnt <= cnt + 1'b1;
    end
  end

endmodule

// File: rtl/irtx_sequencer.sv
module irtx_sequencer
  import irtx_pkg::*;
#(
  parameter  int DATA_W = 32,
  parameter  int WID_W  = 8,
  parameter  int UNIT_W = 16,
  parameter  int CAR_W  = 8,
  localparam int CNT_W  = $clog2(DATA_W)
) (
  input  logic                     clk,
  input  logic                     rst,
  input  logic                     start,
  input  logic                     stop,
  input  logic                     tick,
  input  logic                     car,
  input  irtx_flags_t              flags_i,
  input  logic [N_KIND-1:0][WID_W-1:0] w1_i,
  input  logic [N_KIND-1:0][WID_W-1:0] w0_i,
  input  logic [UNIT_W-1:0]        unit_i,
  input  logic [CAR_W-1:0]         car_hi_i,
  input  logic [CAR_W-1:0]         car_lo_i,
  input  logic [CNT_W-1:0]         nbits_i,
  input  logic [DATA_W-1:0]        data_i,
  output logic                     accept_o,
  output logic                     busy_o,
  output logic                     done_o,
  output logic                     line_o,
  output logic [UNIT_W-1:0]        unit_o,
  output logic [CAR_W-1:0]         car_hi_o,
  output logic [CAR_W-1:0]         car_lo_o
);

  irtx_flags_t                  flags_q;
  logic [N_KIND-1:0][WID_W-1:0] w1_q, w0_q;
  logic [UNIT_W-1:0]            unit_q;
  logic [CAR_W-1:0]             chi_q, clo_q;
  logic [CNT_W-1:0]             nb_q;
  logic [DATA_W-1:0]            data_q;

  seg_e             seg;
  logic             ph;        // 1: first phase, 0: second phase
  logic [WID_W-1:0] uc;
  logic [CNT_W-1:0] bi;
  logic             stop_q;
  logic             done_q;

  function automatic seg_e first_of(irtx_flags_t f);
    if (f.head_en)      return SEG_HEAD;
    else if (f.data_en) return SEG_DATA;
    else if (f.tail_en) return SEG_TAIL;
    else if (!f.cont)   return SEG_GAP;
    else                return SEG_IDLE;
  endfunction

  // SEG_IDLE as a result means "frame complete"
  function automatic seg_e after(seg_e s, irtx_flags_t f);
    seg_e r;
    r = SEG_IDLE;
    case (s)
      SEG_HEAD: r = f.data_en ? SEG_DATA : f.tail_en ? SEG_TAIL : !f.cont ? SEG_GAP : SEG_IDLE;
      SEG_DATA: r = f.tail_en ? SEG_TAIL : !f.cont ? SEG_GAP : SEG_IDLE;
      SEG_TAIL: r = !f.cont ? SEG_GAP : SEG_IDLE;
      default:  r = SEG_IDLE;
    endcase
    return r;
  endfunction

  logic             cur_bit;
  int unsigned      kind;
  logic [WID_W-1:0] w_cur;
  logic             swap_cur;
  logic             lvl;
  logic [CNT_W-1:0] last_bit;
  logic             phase_end;
  logic             more_bits;
  seg_e             nxt;
  logic             again;

  always_comb begin
    cur_bit = data_q[bi];
    case (seg)
      SEG_HEAD: kind = K_HEAD;
      SEG_DATA: kind = cur_bit ? K_ONE : K_ZERO;
      default:  kind = K_TAIL;
    endcase
    w_cur = ph ? w1_q[kind] : w0_q[kind];
    case (seg)
      SEG_HEAD: swap_cur = flags_q.head_swap;
      SEG_DATA: swap_cur = cur_bit ? flags_q.one_swap : flags_q.zero_swap;
      SEG_TAIL: swap_cur = flags_q.tail_swap;
      default:  swap_cur = 1'b0;
    endcase
    lvl = (seg == SEG_HEAD || seg == SEG_DATA || seg == SEG_TAIL) ? (ph ^ swap_cur) : 1'b0;
  end

  assign last_bit  = flags_q.freerun ? CNT_W'(DATA_W - 1) : nb_q;
  assign busy_o    = (seg != SEG_IDLE);
  assign phase_end = busy_o && tick && (uc == w_cur);
  assign more_bits = (seg == SEG_DATA) && (bi != last_bit);
  assign nxt       = after(seg, flags_q);
  assign again     = flags_q.freerun && !stop_q && !stop;
  assign accept_o  = start && !busy_o && (first_of(flags_i) != SEG_IDLE);
  assign line_o    = flags_q.inv_out ^ (lvl & (flags_q.mod_en ? car : 1'b1));
  assign done_o    = done_q;
  assign unit_o    = unit_q;
  assign car_hi_o  = chi_q;
  assign car_lo_o  = clo_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      flags_q <= '0;
      w1_q    <= '0;
      w0_q    <= '0;
      unit_q  <= '0;
      chi_q   <= '0;
      clo_q   <= '0;
      nb_q    <= '0;
      data_q  <= '0;
      seg     <= SEG_IDLE;
      ph      <= 1'b1;
      uc      <= '0;
      bi      <= '0;
      stop_q  <= 1'b0;
      done_q  <= 1'b0;
    end else begin
      done_q <= 1'b0;
      if (accept_o) begin
        flags_q <= flags_i;
        w1_q    <= w1_i;
        w0_q    <= w0_i;
        unit_q  <= unit_i;
        chi_q   <= car_hi_i;
        clo_q   <= car_lo_i;
        nb_q    <= nbits_i;
        data_q  <= data_i;
        seg     <= first_of(flags_i);
        ph      <= 1'b1;
        uc      <= '0;
        bi      <= '0;
        stop_q  <= 1'b0;
      end else if (busy_o) begin
        if (stop) stop_q <= 1'b1;
        if (phase_end) begin
          uc <= '0;
          if (ph) begin
            ph <= 1'b0;
          end else begin
            ph <= 1'b1;
            if (more_bits) begin
              bi <= bi + 1'b1;
            end else begin
              bi <= '0;
              if (nxt != SEG_IDLE) begin
                seg <= nxt;
              end else if (again) begin
                seg <= first_of(flags_q);
              end else begin
                seg    <= SEG_IDLE;
                done_q <= 1'b1;
              end
            end
          end
        end else if (tick) begin
          uc <= uc + 1'b1;
        end
      end
    end
  end

  // R3: without a unit tick the symbol position cannot move
  assert_phase_hold_R3: assert property (@(posedge clk) disable iff (rst)
    (busy_o && !tick && !accept_o) |=> (seg == $past(seg) && ph == $past(ph)));

  // R5: the data bit index stays within the selected count
  assert_bit_range_R5: assert property (@(posedge clk) disable iff (rst)
    (seg == SEG_DATA) |-> (bi <= last_bit));

endmodule

// File: rtl/irtx_frame.sv
module irtx_frame
  import irtx_pkg::*;
#(
  parameter  int DATA_W = 32,
  parameter  int WID_W  = 8,
  parameter  int UNIT_W = 16,
  parameter  int CAR_W  = 8,
  localparam int CNT_W  = $clog2(DATA_W)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              start_i,
  input  logic              stop_i,
  input  logic [UNIT_W-1:0] unit_i,
  input  logic [WID_W-1:0]  head_w1_i,
  input  logic [WID_W-1:0]  head_w0_i,
  input  logic [WID_W-1:0]  one_w1_i,
  input  logic [WID_W-1:0]  one_w0_i,
  input  logic [WID_W-1:0]  zero_w1_i,
  input  logic [WID_W-1:0]  zero_w0_i,
  input  logic [WID_W-1:0]  tail_w1_i,
  input  logic [WID_W-1:0]  tail_w0_i,
  input  logic [CAR_W-1:0]  car_hi_i,
  input  logic [CAR_W-1:0]  car_lo_i,
  input  logic              head_en_i,
  input  logic              data_en_i,
  input  logic              tail_en_i,
  input  logic              head_swap_i,
  input  logic              one_swap_i,
  input  logic              zero_swap_i,
  input  logic              tail_swap_i,
  input  logic              mod_en_i,
  input  logic              inv_out_i,
  input  logic              cont_i,
  input  logic              freerun_i,
  input  logic [CNT_W-1:0]  nbits_i,
  input  logic [DATA_W-1:0] data_i,
  output logic              ir_o,
  output logic              busy_o,
  output logic              done_o
);

  irtx_flags_t                  flags;
  logic [N_KIND-1:0][WID_W-1:0] w1, w0;
  logic                         tick, car, accept, busy, done, line;
  logic [UNIT_W-1:0]            unit_q;
  logic [CAR_W-1:0]             chi_q, clo_q;
  logic                         ir_q, busy_q, done_q;

  assign flags = '{head_en: head_en_i, data_en: data_en_i, tail_en: tail_en_i,
                   head_swap: head_swap_i, one_swap: one_swap_i,
                   zero_swap: zero_swap_i, tail_swap: tail_swap_i,
                   mod_en: mod_en_i, inv_out: inv_out_i, cont: cont_i,
                   freerun: freerun_i};

  always_comb begin
    w1[K_HEAD] = head_w1_i;  w0[K_HEAD] = head_w0_i;
    w1[K_ONE]  = one_w1_i;   w0[K_ONE]  = one_w0_i;
    w1[K_ZERO] = zero_w1_i;  w0[K_ZERO] = zero_w0_i;
    w1[K_TAIL] = tail_w1_i;  w0[K_TAIL] = tail_w0_i;
  end

  irtx_unit_timer #(.UNIT_W(UNIT_W)) u_timer (
    .clk(clk), .rst(rst), .restart(accept), .unit(unit_q), .tick(tick)
  );

  irtx_carrier #(.CAR_W(CAR_W)) u_carrier (
    .clk(clk), .rst(rst), .restart(accept), .hi_w(chi_q), .lo_w(clo_q), .car(car)
  );

  irtx_sequencer #(
    .DATA_W(DATA_W), .WID_W(WID_W), .UNIT_W(UNIT_W), .CAR_W(CAR_W)
  ) u_seq (
    .clk(clk), .rst(rst), .start(start_i), .stop(stop_i), .tick(tick), .car(car),
    .flags_i(flags), .w1_i(w1), .w0_i(w0), .unit_i(unit_i),
    .car_hi_i(car_hi_i), .car_lo_i(car_lo_i), .nbits_i(nbits_i), .data_i(data_i),
    .accept_o(accept), .busy_o(busy), .done_o(done), .line_o(line),
    .unit_o(unit_q), .car_hi_o(chi_q), .car_lo_o(clo_q)
  );

  // output stage: line, busy and end pulse leave through one register rank
  always_ff @(posedge clk) begin
    if (rst) begin
      ir_q   <= 1'b0;
      busy_q <= 1'b0;
      done_q <= 1'b0;
    end else begin
      ir_q   <= busy ? line : inv_out_i;
      busy_q <= busy;
      done_q <= done;
    end
  end

  assign ir_o   = ir_q;
  assign busy_o = busy_q;
  assign done_o = done_q;

  // R10: end pulse lasts one cycle
  assert_done_single_R10: assert property (@(posedge clk) disable iff (rst)
    done_o |=> !done_o);

  // R10: end pulse coincides with busy falling
  assert_done_fall_R10: assert property (@(posedge clk) disable iff (rst)
    done_o |-> $fell(busy_o));

  // R11: a start during a transfer does not reload the timing set
  assert_start_ignored_R11: assert property (@(posedge clk) disable iff (rst)
    (start_i && busy) |=> $stable({unit_q, chi_q, clo_q}));

endmodule

// File: tb/irtx_frame_test.sv
`timescale 1ns/1ps
module irtx_frame_test;

  typedef struct packed {
    logic [15:0] unit;
    logic [7:0]  hw1, hw0, ow1, ow0, zw1, zw0, tw1, tw0, cw1, cw0;
    logic        hen, den, ten, hswap, oswap, zswap, tswap, mod, inv, cont, frun;
    logic [4:0]  nbits;
    logic [31:0] data;
    logic [15:0] exp_t;
  } vec_t;

  localparam int NV = 5;
  localparam vec_t VECS [NV] = '{
    '{unit:16'd1, hw1:8'd3, hw0:8'd1, ow1:8'd0, ow0:8'd2, zw1:8'd0, zw0:8'd0,
      tw1:8'd1, tw0:8'd0, cw1:8'd0, cw0:8'd0, hen:1, den:1, ten:1, hswap:0,
      oswap:0, zswap:0, tswap:0, mod:0, inv:0, cont:0, frun:0, nbits:5'd3,
      data:32'h0000_000A, exp_t:16'd48},
    '{unit:16'd0, hw1:8'd1, hw0:8'd1, ow1:8'd1, ow0:8'd3, zw1:8'd1, zw0:8'd0,
      tw1:8'd0, tw0:8'd0, cw1:8'd1, cw0:8'd0, hen:0, den:1, ten:1, hswap:0,
      oswap:0, zswap:1, tswap:0, mod:1, inv:1, cont:1, frun:0, nbits:5'd7,
      data:32'h0000_00C5, exp_t:16'd38},
    '{unit:16'd2, hw1:8'd0, hw0:8'd1, ow1:8'd0, ow0:8'd0, zw1:8'd0, zw0:8'd0,
      tw1:8'd2, tw0:8'd1, cw1:8'd0, cw0:8'd0, hen:1, den:0, ten:0, hswap:1,
      oswap:0, zswap:0, tswap:1, mod:0, inv:0, cont:0, frun:0, nbits:5'd0,
      data:32'h0, exp_t:16'd24},
    '{unit:16'd0, hw1:8'd0, hw0:8'd0, ow1:8'd0, ow0:8'd1, zw1:8'd1, zw0:8'd0,
      tw1:8'd0, tw0:8'd0, cw1:8'd2, cw0:8'd2, hen:0, den:1, ten:0, hswap:0,
      oswap:1, zswap:0, tswap:0, mod:1, inv:0, cont:1, frun:0, nbits:5'd31,
      data:32'h8000_0001, exp_t:16'd96},
    '{unit:16'd3, hw1:8'd0, hw0:8'd0, ow1:8'd0, ow0:8'd0, zw1:8'd0, zw0:8'd0,
      tw1:8'd0, tw0:8'd0, cw1:8'd0, cw0:8'd0, hen:1, den:1, ten:1, hswap:0,
      oswap:0, zswap:0, tswap:1, mod:0, inv:1, cont:0, frun:0, nbits:5'd0,
      data:32'h1, exp_t:16'd32}
  };

  localparam int MAXC = 4096;

  logic clk = 0, rst = 1;
  logic start_i = 0, stop_i = 0;
  logic [15:0] unit_i = 0;
  logic [7:0] head_w1_i = 0, head_w0_i = 0, one_w1_i = 0, one_w0_i = 0;
  logic [7:0] zero_w1_i = 0, zero_w0_i = 0, tail_w1_i = 0, tail_w0_i = 0;
  logic [7:0] car_hi_i = 0, car_lo_i = 0;
  logic head_en_i = 0, data_en_i = 0, tail_en_i = 0;
  logic head_swap_i = 0, one_swap_i = 0, zero_swap_i = 0, tail_swap_i = 0;
  logic mod_en_i = 0, inv_out_i = 0, cont_i = 0, freerun_i = 0;
  logic [4:0] nbits_i = 0;
  logic [31:0] data_i = 0;
  logic ir_o, busy_o, done_o;

  int n_chk = 0, n_bad = 0;
  bit finished = 0;
  bit exp_lvl [MAXC];
  int mt;
  int cur_unit;

  always #2.5 clk = ~clk;

  irtx_frame uut (
    .clk(clk), .rst(rst), .start_i(start_i), .stop_i(stop_i), .unit_i(unit_i),
    .head_w1_i(head_w1_i), .head_w0_i(head_w0_i), .one_w1_i(one_w1_i),
    .one_w0_i(one_w0_i), .zero_w1_i(zero_w1_i), .zero_w0_i(zero_w0_i),
    .tail_w1_i(tail_w1_i), .tail_w0_i(tail_w0_i), .car_hi_i(car_hi_i),
    .car_lo_i(car_lo_i), .head_en_i(head_en_i), .data_en_i(data_en_i),
    .tail_en_i(tail_en_i), .head_swap_i(head_swap_i), .one_swap_i(one_swap_i),
    .zero_swap_i(zero_swap_i), .tail_swap_i(tail_swap_i), .mod_en_i(mod_en_i),
    .inv_out_i(inv_out_i), .cont_i(cont_i), .freerun_i(freerun_i),
    .nbits_i(nbits_i), .data_i(data_i), .ir_o(ir_o), .busy_o(busy_o), .done_o(done_o)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic set_cfg(input vec_t v);
    unit_i = v.unit; head_w1_i = v.hw1; head_w0_i = v.hw0;
    one_w1_i = v.ow1; one_w0_i = v.ow0; zero_w1_i = v.zw1; zero_w0_i = v.zw0;
    tail_w1_i = v.tw1; tail_w0_i = v.tw0; car_hi_i = v.cw1; car_lo_i = v.cw0;
    head_en_i = v.hen; data_en_i = v.den; tail_en_i = v.ten;
    head_swap_i = v.hswap; one_swap_i = v.oswap; zero_swap_i = v.zswap;
    tail_swap_i = v.tswap; mod_en_i = v.mod; inv_out_i = v.inv; cont_i = v.cont;
    freerun_i = v.frun; nbits_i = v.nbits; data_i = v.data;
  endtask

  task automatic push(input bit l, input int units);
    for (int i = 0; i < units * (cur_unit + 1); i++) begin
      exp_lvl[mt] = l;
      mt++;
    end
  endtask

  // symbol: first phase active unless swapped (R3, R4)
  task automatic symbol(input bit swap, input int w1, input int w0);
    push(!swap, w1 + 1);
    push(swap, w0 + 1);
  endtask

  task automatic build(input vec_t v, input int frames);
    int nb;
    mt = 0;
    cur_unit = int'(v.unit);
    nb = v.frun ? 32 : int'(v.nbits) + 1;
    for (int f = 0; f < frames; f++) begin
      if (v.hen) symbol(v.hswap, v.hw1, v.hw0);
      if (v.den)
        for (int i = 0; i < nb; i++) begin
          if (v.data[i]) symbol(v.oswap, v.ow1, v.ow0);
          else           symbol(v.zswap, v.zw1, v.zw0);
        end
      if (v.ten) symbol(v.tswap, v.tw1, v.tw0);
      if (!v.cont) begin
        push(1'b0, int'(v.tw1) + 1);
        push(1'b0, int'(v.tw0) + 1);
      end
    end
  endtask

  // start a transfer and compare every cycle with the model
  task automatic run(input vec_t v, input int frames, input int stop_at,
                     input int poke_at, input string tag);
    int bad_line, bad_bd, first_k, act_l, exp_l, period;
    bit el;
    build(v, frames);
    bad_line = 0; bad_bd = 0; first_k = -1; act_l = 0; exp_l = 0;
    period = int'(v.cw1) + int'(v.cw0) + 2;
    @(negedge clk);
    set_cfg(v);
    start_i = 1;
    @(negedge clk);
    start_i = 0;
    for (int k = 0; k <= mt + 1; k++) begin
      @(negedge clk);
      if (k < mt)
        el = v.inv ^ (exp_lvl[k] & (!v.mod || ((k % period) < int'(v.cw1) + 1)));
      else
        el = inv_out_i;
      if (ir_o !== el) begin
        if (bad_line == 0) begin first_k = k; act_l = ir_o; exp_l = el; end
        bad_line++;
      end
      if (busy_o !== (k < mt) || done_o !== (k == mt)) bad_bd++;
      if (k == poke_at) begin
        start_i = 1; unit_i = 16'd7; data_i = 32'h0; head_en_i = 0; inv_out_i = v.inv;
      end else begin
        start_i = 0;
      end
      stop_i = (k == stop_at);
    end
    start_i = 0; stop_i = 0;
    if (bad_line != 0) $display("  %s: first line mismatch at cycle %0d", tag, first_k);
    chk(bad_line == 0, {tag, " line"}, act_l, exp_l);
    chk(bad_bd == 0, {tag, " R10 busy/done timing"}, bad_bd, 0);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    vec_t fr;
    // R1: reset state
    repeat (4) @(negedge clk);
    chk(ir_o == 0 && busy_o == 0 && done_o == 0, "R1 reset outputs", {ir_o, busy_o, done_o}, 0);
    rst = 0;
    @(negedge clk);

    // R7: idle level follows the live inversion input
    inv_out_i = 1;
    repeat (2) @(negedge clk);
    chk(ir_o == 1, "R7 idle level high", ir_o, 1);
    inv_out_i = 0;
    repeat (2) @(negedge clk);
    chk(ir_o == 0, "R7 idle level low", ir_o, 0);

    // table: R2 R3 R4 R5 R6 R7 R8 over several settings
    for (int i = 0; i < NV; i++) begin
      build(VECS[i], 1);
      chk(mt == int'(VECS[i].exp_t), "R3 R8 frame length", mt, int'(VECS[i].exp_t));
      run(VECS[i], 1, -1, -1, $sformatf("R2 R3 R4 R5 R6 R7 R8 vec%0d", i));
      repeat (3) @(negedge clk);
    end

    // R11: start plus changed settings mid-frame leave the frame untouched
    run(VECS[0], 1, -1, 10, "R11 start while busy");
    repeat (3) @(negedge clk);

    // R11: nothing enabled with continue mode: start has no effect
    fr = VECS[1];
    fr.hen = 0; fr.den = 0; fr.ten = 0; fr.cont = 1;
    @(negedge clk);
    set_cfg(fr);
    start_i = 1;
    @(negedge clk);
    start_i = 0;
    begin
      int seen = 0;
      for (int k = 0; k < 6; k++) begin
        @(negedge clk);
        if (busy_o || done_o) seen++;
      end
      chk(seen == 0, "R11 empty frame ignored", seen, 0);
    end

    // R9: free-run, bit count ignored, stop mid second frame
    fr = VECS[0];
    fr.unit = 0; fr.hw1 = 0; fr.hw0 = 0; fr.ow1 = 0; fr.ow0 = 0;
    fr.zw1 = 0; fr.zw0 = 0; fr.tw1 = 0; fr.tw0 = 0; fr.ten = 0;
    fr.frun = 1; fr.nbits = 0; fr.data = 32'hA5A5_0F0F;
    build(fr, 1);
    chk(mt == 68, "R9 free-run frame length", mt, 68);
    run(fr, 2, 80, -1, "R9 free-run stop in frame two");
    repeat (3) @(negedge clk);
    // R9: stop sampled on the last cycle of frame one ends there
    run(fr, 1, 66, -1, "R9 stop at frame boundary");
    repeat (3) @(negedge clk);
    // R9: stop one cycle later lets frame two run
    run(fr, 2, 67, -1, "R9 stop just after boundary");
    repeat (3) @(negedge clk);

    finished = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

endmodule